// File: doc/BRIEF.md
# PWM Channel Register Bank

This block is the byte-wide register store that sits behind a serial slave front end in a multi-channel PWM controller. The front end hands it one-cycle strobes for a bus start, a bus stop, a received byte and a requested byte. After a start, the first byte received loads a register pointer. Each later byte writes the register that the pointer selects, and each requested byte returns the content of that register. The block drives the tick values, mode flags and prescale value that the PWM counter logic uses.

The address space holds two mode registers, one group of four byte registers for each channel, a broadcast group of four bytes that reaches every channel, and a prescale register. Channel writes first land in shadow copies. They reach the active outputs either on a bus stop or on the byte that wrote them, depending on a mode flag. This lets software retune many channels and have every output switch at once.

Top module: `pwm_regbank`

## Requirements
- R1: The first byte received after a start strobe loads the register pointer. A value above the last register address (70 with 16 channels) loads 0.
- R2: When the auto-increment flag (mode-1 bit 1) is set, the pointer advances by one after each data byte written or read, and moves from address 70 back to 0. When the flag is clear, the pointer stays where it is.
- R3: Channel n occupies addresses 2+4n to 5+4n, in this order: on-tick bits 7:0, on-tick bits 12:8 (taken from data bits 4:0), off-tick bits 7:0, off-tick bits 12:8.
- R4: A byte written to broadcast address 66+k (k = 0..3) updates lane k of every channel's shadow.
- R5: Mode-1 is at address 0 (bit 0 sleep, bit 1 auto-increment, bit 2 external clock) and resets to 0x01. Mode-2 is at address 1 (bit 0 invert, bit 1 output drive, bit 2 update-per-byte) and resets to 0x02. Upper bits read as zero. Each flag drives its output pin.
- R6: Prescale is at address 70 and resets to 30. A write to it takes effect only while the sleep flag is set; otherwise it is ignored.
- R7: An accepted prescale write with a value below 3 stores 3.
- R8: With update-per-byte clear, channel outputs keep their values until a stop strobe. On the stop strobe, every channel's shadow is copied to its outputs.
- R9: With update-per-byte set, a byte that writes a channel copies that channel's whole shadow to its outputs on the same clock edge.
- R10: A byte request returns, one cycle later on the read port, the active value of the selected register. Broadcast addresses read as zero. The read port holds its value between requests.
- R11: After reset, every channel's on and off ticks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Bus start or repeated-start strobe |
| stop_i | input | 1 | Bus stop strobe |
| wr_byte_i | input | 1 | A received byte is valid on wr_data_i |
| wr_data_i | input | 8 | Received byte |
| rd_req_i | input | 1 | The front end requests a byte to send |
| rd_data_o | output | 8 | Byte to send, valid the cycle after rd_req_i |
| chan_on_o | output | 13*NCH | Active on-ticks, channel n at bits 13n+12:13n |
| chan_off_o | output | 13*NCH | Active off-ticks, same packing |
| prescale_o | output | 8 | Stored prescale value |
| sleep_o | output | 1 | Sleep flag |
| extclk_o | output | 1 | External clock select flag |
| invert_o | output | 1 | Output invert flag |
| outdrv_o | output | 1 | Output drive style flag |

## Verification
A wrong pointer shows up on the first read that follows, because the byte returned comes from the wrong address. A wrong staged shadow stays hidden until the next stop strobe or per-byte copy moves it onto the channel tick outputs, so the outputs are compared against a model after every transaction. A wrong mode or prescale bit appears on its output pin on the next clock edge. The bench mixes random transactions with directed cases: pointer wrap, overflow of the pointer byte, a prescale write while awake, broadcast writes and the two update timings.

// File: rtl/pwm_regbank_pkg.sv
package pwm_regbank_pkg;
  localparam int TICK_W = 13;

  typedef enum logic [1:0] {
    LANE_ON_LO  = 2'd0,
    LANE_ON_HI  = 2'd1,
    LANE_OFF_LO = 2'd2,
    LANE_OFF_HI = 2'd3
  } lane_e;

  typedef struct packed {
    logic [TICK_W-1:0] on;
    logic [TICK_W-1:0] off;
  } ticks_t;

  localparam int M1_SLEEP = 0;
  localparam int M1_AINC  = 1;
  localparam int M1_EXTCK = 2;
  localparam int M2_INV   = 0;
  localparam int M2_DRV   = 1;
  localparam int M2_OCH   = 2;
  localparam logic [2:0] MODE1_RST = 3'b001;
  localparam logic [2:0] MODE2_RST = 3'b010;

  function automatic ticks_t put_lane(ticks_t t, lane_e l, logic [7:0] d);
    ticks_t r = t;
    case (l)
      LANE_ON_LO:  r.on[7:0]          = d;
      LANE_ON_HI:  r.on[TICK_W-1:8]   = d[TICK_W-9:0];
      LANE_OFF_LO: r.off[7:0]         = d;
      default:     r.off[TICK_W-1:8]  = d[TICK_W-9:0];
    endcase
    return r;
  endfunction

  function automatic logic [7:0] get_lane(ticks_t t, lane_e l);
    logic [7:0] r;
    case (l)
      LANE_ON_LO:  r = t.on[7:0];
      LANE_ON_HI:  r = 8'(t.on[TICK_W-1:8]);
      LANE_OFF_LO: r = t.off[7:0];
      default:     r = 8'(t.off[TICK_W-1:8]);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pwm_regbank_ptr.sv
module pwm_regbank_ptr #(
  parameter int LAST  = 70,
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wr_byte_i,
  input  logic             rd_req_i,
  input  logic [7:0]       data_i,
  input  logic             ainc_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             data_wr_o
);
  logic             expect_q, expect_d;
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc, ptr_load;

  assign ptr_inc   = (int'(ptr_q) == LAST) ? '0 : ptr_q + 1'b1;
  assign ptr_load  = (int'(data_i) > LAST) ? '0 : PTR_W'(data_i);
  assign data_wr_o = wr_byte_i & ~expect_q & ~start_i;
  assign ptr_o     = ptr_q;

  always_comb begin
    expect_d = expect_q;
    ptr_d    = ptr_q;
    if (start_i) begin
      expect_d = 1'b1;
    end else if (wr_byte_i && expect_q) begin
      ptr_d    = ptr_load;
      expect_d = 1'b0;
    end else if ((wr_byte_i || rd_req_i) && ainc_i) begin
      ptr_d = ptr_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_q <= 1'b1;
      ptr_q    <= '0;
    end else begin
      expect_q <= expect_d;
      ptr_q    <= ptr_d;
    end
  end

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) <= LAST);
  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr_o || (rd_req_i && !wr_byte_i)) && !ainc_i && !start_i |=> $stable(ptr_q));
endmodule

// File: rtl/pwm_regbank_chan.sv
module pwm_regbank_chan
  import pwm_regbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  lane_e      lane_i,
  input  logic [7:0] data_i,
  input  logic       och_i,
  input  logic       stop_i,
  output ticks_t     act_o
);
  ticks_t sh_q, sh_d, act_q, act_d;

  always_comb begin
    sh_d  = sh_q;
    act_d = act_q;
    if (wr_i) sh_d = put_lane(sh_q, lane_i, data_i);
    if (stop_i)            act_d = sh_q;
    else if (wr_i && och_i) act_d = sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;

  assert_staged_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !och_i && !stop_i |=> $stable(act_q));
  assert_byte_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && och_i && !stop_i |=> act_q == sh_q);
endmodule

// File: rtl/pwm_regbank_ctrl.sv
module pwm_regbank_ctrl
  import pwm_regbank_pkg::*;
#(
  parameter int PRE_RST = 30,
  parameter int PRE_MIN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_m1_i,
  input  logic       wr_m2_i,
  input  logic       wr_pre_i,
  input  logic [7:0] data_i,
  output logic [2:0] mode1_o,
  output logic [2:0] mode2_o,
  output logic [7:0] pre_o
);
  logic [2:0] m1_q, m1_d, m2_q, m2_d;
  logic [7:0] pre_q, pre_d;

  always_comb begin
    m1_d  = m1_q;
    m2_d  = m2_q;
    pre_d = pre_q;
    if (wr_m1_i) m1_d = data_i[2:0];
    if (wr_m2_i) m2_d = data_i[2:0];
    if (wr_pre_i && m1_q[M1_SLEEP])
      pre_d = (int'(data_i) < PRE_MIN) ? 8'(PRE_MIN) : data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q  <= MODE1_RST;
      m2_q  <= MODE2_RST;
      pre_q <= 8'(PRE_RST);
    end else begin
      m1_q  <= m1_d;
      m2_q  <= m2_d;
      pre_q <= pre_d;
    end
  end

  assign mode1_o = m1_q;
  assign mode2_o = m2_q;
  assign pre_o   = pre_q;

  assert_pre_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !m1_q[M1_SLEEP] |=> $stable(pre_q));
  assert_pre_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pre_i && m1_q[M1_SLEEP] |=> int'(pre_q) >= PRE_MIN);
endmodule

// File: rtl/pwm_regbank.sv
module pwm_regbank
  import pwm_regbank_pkg::*;
#(
  parameter int NCH     = 16,
  parameter int PRE_RST = 30,
  parameter int PRE_MIN = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  wr_byte_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  rd_req_i,
  output logic [7:0]            rd_data_o,
  output logic [TICK_W*NCH-1:0] chan_on_o,
  output logic [TICK_W*NCH-1:0] chan_off_o,
  output logic [7:0]            prescale_o,
  output logic                  sleep_o,
  output logic                  extclk_o,
  output logic                  invert_o,
  output logic                  outdrv_o
);
  localparam int CH_BASE  = 2;
  localparam int ALL_BASE = CH_BASE + 4 * NCH;
  localparam int PRE_ADDR = ALL_BASE + 4;
  localparam int LAST     = PRE_ADDR;
  localparam int PTR_W    = $clog2(LAST + 1);
  localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1;

  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic [PTR_W-1:0] ptr;
  logic             data_wr;
  logic [2:0]       mode1, mode2;
  logic             in_chan, in_all;
  int               rel;
  logic [CH_W-1:0]  ch_sel;
  lane_e            lane;
  logic [7:0]       rd_val, rd_q, rd_d;
  ticks_t           act_w [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  pwm_regbank_ptr #(.LAST(LAST), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_core_n), .start_i(start_i), .wr_byte_i(wr_byte_i),
    .rd_req_i(rd_req_i), .data_i(wr_data_i), .ainc_i(mode1[M1_AINC]),
    .ptr_o(ptr), .data_wr_o(data_wr));

  pwm_regbank_ctrl #(.PRE_RST(PRE_RST), .PRE_MIN(PRE_MIN)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .wr_m1_i(data_wr && int'(ptr) == 0),
    .wr_m2_i(data_wr && int'(ptr) == 1),
    .wr_pre_i(data_wr && int'(ptr) == PRE_ADDR),
    .data_i(wr_data_i), .mode1_o(mode1), .mode2_o(mode2), .pre_o(prescale_o));

  always_comb begin
    rel     = int'(ptr) - CH_BASE;
    in_chan = (int'(ptr) >= CH_BASE) && (int'(ptr) < ALL_BASE);
    in_all  = (int'(ptr) >= ALL_BASE) && (int'(ptr) < PRE_ADDR);
    ch_sel  = in_chan ? CH_W'(rel >> 2) : '0;
    lane    = in_all ? lane_e'(2'(int'(ptr) - ALL_BASE)) : lane_e'(2'(rel));
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    pwm_regbank_chan u_chan (
      .clk(clk), .rst_n(rst_core_n),
      .wr_i(data_wr && (in_all || (in_chan && ch_sel == CH_W'(i)))),
      .lane_i(lane), .data_i(wr_data_i), .och_i(mode2[M2_OCH]),
      .stop_i(stop_i), .act_o(act_w[i]));
    assign chan_on_o[TICK_W*i +: TICK_W]  = act_w[i].on;
    assign chan_off_o[TICK_W*i +: TICK_W] = act_w[i].off;
  end

  always_comb begin
    if (int'(ptr) == 0)      rd_val = {5'b0, mode1};
    else if (int'(ptr) == 1) rd_val = {5'b0, mode2};
    else if (in_chan)        rd_val = get_lane(act_w[ch_sel], lane);
    else if (in_all)         rd_val = '0;
    else                     rd_val = prescale_o;
    rd_d = rd_req_i ? rd_val : rd_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rd_q <= '0;
    else             rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
  assign sleep_o   = mode1[M1_SLEEP];
  assign extclk_o  = mode1[M1_EXTCK];
  assign invert_o  = mode2[M2_INV];
  assign outdrv_o  = mode2[M2_DRV];

  assert_group_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    rd_req_i && in_all |=> rd_data_o == 8'h00);
  assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rd_req_i |=> $stable(rd_data_o));
endmodule

// File: tb/pwm_regbank_test.sv
`timescale 1ns/1ps
module pwm_regbank_test;
  localparam int NCH = 16;
  localparam int LASTA = 70;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, wr_byte_i = 1'b0, rd_req_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o, prescale_o;
  logic [13*NCH-1:0] chan_on_o, chan_off_o;
  logic sleep_o, extclk_o, invert_o, outdrv_o;

  pwm_regbank #(.NCH(NCH)) uut (.*);

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0;
  int m_ptr = 0;
  bit m_expect = 1'b1;
  logic [2:0] m1 = 3'b001, m2 = 3'b010;
  int m_pre = 30;
  logic [12:0] sh_on [NCH], sh_off [NCH], ac_on [NCH], ac_off [NCH];
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_read(int a);
    int ch, ln;
    if (a == 0) return int'(m1);
    if (a == 1) return int'(m2);
    if (a >= 66 && a <= 69) return 0;
    if (a == LASTA) return m_pre;
    ch = (a - 2) / 4; ln = (a - 2) % 4;
    case (ln)
      0: return int'(ac_on[ch][7:0]);
      1: return int'(ac_on[ch][12:8]);
      2: return int'(ac_off[ch][7:0]);
      default: return int'(ac_off[ch][12:8]);
    endcase
  endfunction

  function automatic void put(int ch, int ln, logic [7:0] d);
    case (ln)
      0: sh_on[ch][7:0] = d;
      1: sh_on[ch][12:8] = d[4:0];
      2: sh_off[ch][7:0] = d;
      default: sh_off[ch][12:8] = d[4:0];
    endcase
    if (m2[2]) begin ac_on[ch] = sh_on[ch]; ac_off[ch] = sh_off[ch]; end
  endfunction

  function automatic void model_write(int a, logic [7:0] d);
    if (a == 0) m1 = d[2:0];
    else if (a == 1) m2 = d[2:0];
    else if (a >= 2 && a < 66) put((a - 2) / 4, (a - 2) % 4, d);
    else if (a < LASTA) begin
      for (int c = 0; c < NCH; c++) put(c, a - 66, d);
    end else if (m1[0]) m_pre = (d < 3) ? 3 : int'(d);
  endfunction

  task automatic do_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    m_expect = 1'b1;
  endtask

  task automatic do_stop();
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    for (int c = 0; c < NCH; c++) begin ac_on[c] = sh_on[c]; ac_off[c] = sh_off[c]; end
  endtask

  task automatic send(input logic [7:0] b);
    bit ai;
    wr_byte_i = 1'b1; wr_data_i = b; @(negedge clk); wr_byte_i = 1'b0;
    if (m_expect) begin
      m_ptr = (int'(b) > LASTA) ? 0 : int'(b);
      m_expect = 1'b0;
    end else begin
      ai = m1[1];
      model_write(m_ptr, b);
      if (ai) m_ptr = (m_ptr == LASTA) ? 0 : m_ptr + 1;
    end
  endtask

  task automatic fetch(input string req);
    int e;
    e = exp_read(m_ptr);
    rd_req_i = 1'b1; @(negedge clk); rd_req_i = 1'b0;
    chk(req, int'(rd_data_o), e);
    if (m1[1]) m_ptr = (m_ptr == LASTA) ? 0 : m_ptr + 1;
  endtask

  task automatic check_outs(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk(req, int'(chan_on_o[13*c +: 13]), int'(ac_on[c]));
      chk(req, int'(chan_off_o[13*c +: 13]), int'(ac_off[c]));
    end
    chk({req, " prescale"}, int'(prescale_o), m_pre);
    chk({req, " mode flags"}, int'({sleep_o, extclk_o, invert_o, outdrv_o}),
        int'({m1[0], m1[2], m2[0], m2[1]}));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    for (int c = 0; c < NCH; c++) begin
      sh_on[c] = '0; sh_off[c] = '0; ac_on[c] = '0; ac_off[c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check_outs("R11 reset R5 R6");

    do_start(); send(8'd0); fetch("R5 mode1 read");
    do_start(); send(8'd0); send(8'h03); do_stop();
    chk("R5 AI set", int'(m1), 3);
    do_start(); send(8'd70); send(8'h01); do_stop();
    chk("R7 clamp", int'(prescale_o), 3);

    do_start(); send(8'd22); send(8'h34); send(8'hFF); send(8'h78); send(8'h12);
    check_outs("R8 before stop");
    do_start(); send(8'd22); fetch("R10 old value before stop");
    do_stop();
    check_outs("R3 R8 after stop");
    chk("R3 ch5 on", int'(chan_on_o[13*5 +: 13]), 13'h1F34);
    chk("R3 ch5 off", int'(chan_off_o[13*5 +: 13]), 13'h1278);
    do_start(); send(8'd22); fetch("R10 R3"); fetch("R10 R3"); fetch("R10 R3"); fetch("R10 R3");

    do_start(); send(8'd0); send(8'h02); do_stop();
    do_start(); send(8'd70); send(8'h50); do_stop();
    chk("R6 ignored awake", int'(prescale_o), 3);

    do_start(); send(8'd70); fetch("R2 wrap"); fetch("R2 wrap"); fetch("R2 wrap");

    do_start(); send(8'd0); send(8'h00); do_stop();
    do_start(); send(8'd10); send(8'hA5); send(8'h5A); do_stop();
    do_start(); send(8'd10); fetch("R2 hold"); fetch("R2 hold");
    check_outs("R2 hold outputs");

    do_start(); send(8'hC8); fetch("R1 overflow pointer");
    chk("R1 ptr model", m_ptr, 0);

    do_start(); send(8'd0); send(8'h02); do_stop();
    do_start(); send(8'd66); send(8'h11); send(8'h0A); send(8'h22); send(8'h0B); do_stop();
    check_outs("R4 broadcast");
    do_start(); send(8'd66); fetch("R10 group zero"); fetch("R10 group zero");

    do_start(); send(8'd1); send(8'h06); do_stop();
    do_start(); send(8'd30); send(8'h77); send(8'h03);
    check_outs("R9 per byte");
    do_stop();

    for (int it = 0; it < 80; it++) begin
      int nops;
      do_start();
      send(8'($urandom_range(0, 75)));
      nops = $urandom_range(1, 6);
      for (int k = 0; k < nops; k++) begin
        if ($urandom_range(0, 2) == 0) fetch("R10 random read");
        else send(8'($urandom()));
      end
      if ($urandom_range(0, 3) != 0) do_stop();
      check_outs("R8 R9 random");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule